// File: doc/BRIEF.md
# Seed Versus Hopping Word Selector

This block chooses, one code word at a time, whether a remote-control encoder sends its stored fixed seed word or a normal rolling (hopping) code word. It watches the four debounced button lines, two configuration fields (a bank select that picks which button pairs and which hold delay apply, and a two-bit seed mode), the 16-bit synchronization counter and a millisecond tick. At the start of every code word the framer pulses `word_start`, and the block latches its decision for that word.

Two button combinations lead to seed words. The immediate combination gives seed from the first word. The delayed combination first sends hopping words and changes to seed only after the buttons have been held for the configured time. The block also forces the function-code nibble to all ones for seed words. It flags the one word whose guard time must be lengthened by three timing elements, because the burst has just changed from hopping to seed.

Top module: `seed_word_select`

## Requirements
- R1: With `seed_bank`=0 and seeding enabled, button pattern `btn`=4'b0101 (bit 3 first) gives a seed word from the first word of the burst.
- R2: With `seed_bank`=1 and seeding enabled, `btn`=4'b1001 gives an immediate seed word. Under that bank, the bank-0 pattern 4'b0101 gives a hopping word, and under bank 0 the pattern 4'b1001 gives a hopping word.
- R3: With `seed_mode`=2'b00, every word is a hopping word, whatever the buttons are.
- R4: With `seed_mode`=2'b01 (limited), seed is allowed only while `sync_cnt` <= 16'h007F. From 16'h0080 upward, both seed patterns give hopping words.
- R5: The delayed pattern (4'b0001 for bank 0, 4'b0011 for bank 1) gives hopping words until it has been held for DLY0_TICKS (default 1600) or DLY1_TICKS (default 3200) ticks, and seed words after that. Modes 01 and 10 enable the delayed path. Mode 11 gives immediate seed only, so the delayed pattern always gives hopping words in that mode.
- R6: `func_code` is 4'b1111 for a seed word. For a hopping word it is the button pattern captured at `word_start`.
- R7: `guard_ext` is 1 for exactly the word that is a seed word directly after a hopping word of the same burst, and 0 for every other word. The first word of a burst never has it.
- R8: The hold time restarts when the button pattern changes and is cleared when all buttons are released (`btn`=0), which also ends the burst.
- R9: A pattern that matches neither seed combination of the selected bank always gives a hopping word.
- R10: After reset, `seed_sel`, `func_code` and `guard_ext` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn | input | 4 | Debounced buttons, bit 3 = S3 |
| seed_bank | input | 1 | Selects pattern pair and hold delay |
| seed_mode | input | 2 | 00 off, 01 limited, 10 full, 11 immediate only |
| sync_cnt | input | 16 | Current synchronization counter |
| ms_tick | input | 1 | One-cycle millisecond tick |
| word_start | input | 1 | Pulse at the start of each code word |
| seed_sel | output | 1 | Current word is a seed word |
| func_code | output | 4 | Function-code nibble for the current word |
| guard_ext | output | 1 | Lengthen guard time by 3 TE for this word |

## Verification
The bench samples words on both sides of each hold delay, with a margin well clear of the exact boundary. A timer compared against the wrong bank's limit, or one that never expires, shows up as a hopping word where a seed word is expected, or the reverse. It splits a hold with a different pattern and with a release. A timer that fails to restart in either case reaches seed too early. It sets the counter to 0x7F and then to 0x80 in limited mode, to catch an off-by-one in the limit. It follows one burst across its hopping-to-seed change, to show that the guard flag rises on that single word only and never on the first word of a burst.

// File: rtl/seed_sel_pkg.sv
package seed_sel_pkg;
  typedef enum logic [1:0] {
    SM_OFF      = 2'b00,
    SM_LIMITED  = 2'b01,
    SM_FULL     = 2'b10,
    SM_IMM_ONLY = 2'b11
  } seed_mode_e;

  localparam logic [3:0] PAT_IMM_B0 = 4'b0101;
  localparam logic [3:0] PAT_DLY_B0 = 4'b0001;
  localparam logic [3:0] PAT_IMM_B1 = 4'b1001;
  localparam logic [3:0] PAT_DLY_B1 = 4'b0011;
  localparam logic [3:0] FUNC_SEED  = 4'b1111;
endpackage

// File: rtl/seed_hold_timer.sv
module seed_hold_timer #(
  parameter int DLY0_TICKS = 1600,
  parameter int DLY1_TICKS = 3200,
  parameter int TW = $clog2(DLY1_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] btn,
  input  logic       long_sel,
  input  logic       tick,
  output logic       done
);
  localparam logic [TW-1:0] LIM0 = TW'(DLY0_TICKS);
  localparam logic [TW-1:0] LIM1 = TW'(DLY1_TICKS);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [3:0]    prev_q;
  logic [TW-1:0] limit;

  assign limit = long_sel ? LIM1 : LIM0;
  assign done  = (btn != 4'b0000) && (btn == prev_q) && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (btn == 4'b0000 || btn != prev_q)
      cnt_d = '0;
    else if (tick && cnt_q < limit)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= btn;
    end
  end

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (btn == 4'b0000) |=> (cnt_q == '0));  // R8
  AST_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (btn != prev_q) |=> (cnt_q == '0));  // R8
endmodule

// File: rtl/seed_pattern_decode.sv
module seed_pattern_decode
  import seed_sel_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] LIMIT = CNT_W'(16'h007F)
) (
  input  logic [3:0]       btn,
  input  logic             bank,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] sync_cnt,
  input  logic             hold_done,
  output logic             seed_now
);
  logic [3:0] imm_pat, dly_pat;
  logic       allowed, dly_ok, imm_hit, dly_hit;

  assign imm_pat = bank ? PAT_IMM_B1 : PAT_IMM_B0;
  assign dly_pat = bank ? PAT_DLY_B1 : PAT_DLY_B0;

  always_comb begin
    unique case (seed_mode_e'(mode))
      SM_OFF:      begin allowed = 1'b0;              dly_ok = 1'b0; end
      SM_LIMITED:  begin allowed = (sync_cnt <= LIMIT); dly_ok = 1'b1; end
      SM_FULL:     begin allowed = 1'b1;              dly_ok = 1'b1; end
      default:     begin allowed = 1'b1;              dly_ok = 1'b0; end
    endcase
  end

  assign imm_hit  = allowed && (btn == imm_pat);
  assign dly_hit  = allowed && dly_ok && (btn == dly_pat) && hold_done;
  assign seed_now = imm_hit || dly_hit;
endmodule

// File: rtl/seed_word_track.sv
module seed_word_track
  import seed_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_start,
  input  logic [3:0] btn,
  input  logic       seed_now,
  output logic       seed_sel,
  output logic [3:0] func_code,
  output logic       guard_ext
);
  logic       seed_q, seed_d, guard_q, guard_d, burst_q, burst_d;
  logic [3:0] func_q, func_d;
  logic       upd_en;

  assign upd_en = word_start || (btn == 4'b0000);

  always_comb begin
    seed_d  = seed_q;
    guard_d = guard_q;
    burst_d = burst_q;
    func_d  = func_q;
    if (btn == 4'b0000) begin
      seed_d  = 1'b0;
      guard_d = 1'b0;
      burst_d = 1'b0;
      func_d  = 4'b0000;
    end else if (word_start) begin
      seed_d  = seed_now;
      guard_d = seed_now && burst_q && !seed_q;
      burst_d = 1'b1;
      func_d  = seed_now ? FUNC_SEED : btn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q  <= 1'b0;
      guard_q <= 1'b0;
      burst_q <= 1'b0;
      func_q  <= 4'b0000;
    end else if (upd_en) begin
      seed_q  <= seed_d;
      guard_q <= guard_d;
      burst_q <= burst_d;
      func_q  <= func_d;
    end
  end

  assign seed_sel  = seed_q;
  assign guard_ext = guard_q;
  assign func_code = func_q;

  AST_GUARD_ONLY_ON_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    guard_ext |-> seed_sel);  // R7
  AST_GUARD_AFTER_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && btn != 4'b0000 && seed_q) |=> !guard_ext);  // R7
endmodule

// File: rtl/seed_word_select.sv
module seed_word_select #(
  parameter int DLY0_TICKS = 1600,
  parameter int DLY1_TICKS = 3200,
  parameter int CNT_W      = 16,
  parameter int SEED_LIMIT = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       btn,
  input  logic             seed_bank,
  input  logic [1:0]       seed_mode,
  input  logic [CNT_W-1:0] sync_cnt,
  input  logic             ms_tick,
  input  logic             word_start,
  output logic             seed_sel,
  output logic [3:0]       func_code,
  output logic             guard_ext
);
  localparam int TW = $clog2(DLY1_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SEED_LIMIT);

  logic hold_done, seed_now;

  seed_hold_timer #(.DLY0_TICKS(DLY0_TICKS), .DLY1_TICKS(DLY1_TICKS), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .btn(btn), .long_sel(seed_bank),
    .tick(ms_tick), .done(hold_done)
  );

  seed_pattern_decode #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_dec (
    .btn(btn), .bank(seed_bank), .mode(seed_mode), .sync_cnt(sync_cnt),
    .hold_done(hold_done), .seed_now(seed_now)
  );

  seed_word_track u_track (
    .clk(clk), .rst_n(rst_n), .word_start(word_start), .btn(btn),
    .seed_now(seed_now), .seed_sel(seed_sel), .func_code(func_code),
    .guard_ext(guard_ext)
  );

  AST_MODE_OFF_NO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && seed_mode == 2'b00) |=> !seed_sel);  // R3
  AST_LIMIT_ABOVE_NO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && seed_mode == 2'b01 && sync_cnt > LIMIT) |=> !seed_sel);  // R4
  AST_NOMATCH_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && btn != 4'b0101 && btn != 4'b1001 && btn != 4'b0001 && btn != 4'b0011)
      |=> !seed_sel);  // R9
  AST_SEED_FUNC_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    seed_sel |-> (func_code == 4'b1111));  // R6
endmodule

// File: tb/sim_seed_word_select.sv
`timescale 1ns/1ps
module sim_seed_word_select;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  btn;
  logic        seed_bank;
  logic [1:0]  seed_mode;
  logic [15:0] sync_cnt;
  logic        ms_tick;
  logic        word_start;
  logic        seed_sel;
  logic [3:0]  func_code;
  logic        guard_ext;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seed_word_select u0 (
    .clk(clk), .rst_n(rst_n), .btn(btn), .seed_bank(seed_bank),
    .seed_mode(seed_mode), .sync_cnt(sync_cnt), .ms_tick(ms_tick),
    .word_start(word_start), .seed_sel(seed_sel), .func_code(func_code),
    .guard_ext(guard_ext)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] p);
    @(negedge clk);
    btn = p;
  endtask

  task automatic release_all();
    @(negedge clk);
    btn = 4'b0000;
    hold(3);
  endtask

  task automatic word(input string req, input bit s, input logic [3:0] f, input bit g);
    @(negedge clk);
    word_start = 1'b1;
    @(negedge clk);
    word_start = 1'b0;
    chk({req, " seed_sel"}, seed_sel, s);
    chk({req, " func_code"}, func_code, f);
    chk({req, " guard_ext"}, guard_ext, g);
  endtask

  task automatic t_reset();
    chk("R10 seed_sel", seed_sel, 0);
    chk("R10 func_code", func_code, 0);
    chk("R10 guard_ext", guard_ext, 0);
  endtask

  task automatic t_imm_bank0();
    seed_bank = 1'b0; seed_mode = 2'b10; sync_cnt = 16'h1234;
    press(4'b0101); hold(2);
    word("R1 imm bank0", 1'b1, 4'hF, 1'b0);
    word("R7 seed again", 1'b1, 4'hF, 1'b0);
    release_all();
    press(4'b1001); hold(2);
    word("R2 bank1 pattern under bank0", 1'b0, 4'b1001, 1'b0);
    release_all();
  endtask

  task automatic t_imm_bank1();
    seed_bank = 1'b1; seed_mode = 2'b11;
    press(4'b1001); hold(2);
    word("R2 imm bank1", 1'b1, 4'hF, 1'b0);
    release_all();
    press(4'b0101); hold(2);
    word("R2 bank0 pattern under bank1", 1'b0, 4'b0101, 1'b0);
    release_all();
  endtask

  task automatic t_disabled();
    seed_bank = 1'b0; seed_mode = 2'b00;
    press(4'b0101); hold(2);
    word("R3 off imm", 1'b0, 4'b0101, 1'b0);
    release_all();
    press(4'b0001); hold(1700);
    word("R3 off delayed", 1'b0, 4'b0001, 1'b0);
    release_all();
  endtask

  task automatic t_limited();
    seed_bank = 1'b0; seed_mode = 2'b01; sync_cnt = 16'h007F;
    press(4'b0101); hold(2);
    word("R4 limit at 7F", 1'b1, 4'hF, 1'b0);
    release_all();
    sync_cnt = 16'h0080;
    press(4'b0101); hold(2);
    word("R4 limit at 80", 1'b0, 4'b0101, 1'b0);
    release_all();
    sync_cnt = 16'h0010;
    press(4'b0001); hold(1700);
    word("R4 limited delayed", 1'b1, 4'hF, 1'b0);
    release_all();
    sync_cnt = 16'h0200;
    press(4'b0001); hold(1700);
    word("R4 limited delayed above", 1'b0, 4'b0001, 1'b0);
    release_all();
  endtask

  task automatic t_delay();
    seed_bank = 1'b0; seed_mode = 2'b10; sync_cnt = 16'h0500;
    press(4'b0001); hold(5);
    word("R5 bank0 early hop", 1'b0, 4'b0001, 1'b0);
    hold(1490);
    word("R5 bank0 before delay", 1'b0, 4'b0001, 1'b0);
    hold(200);
    word("R7 first seed word", 1'b1, 4'hF, 1'b1);
    word("R7 next seed word", 1'b1, 4'hF, 1'b0);
    release_all();
    seed_bank = 1'b1;
    press(4'b0011); hold(3100);
    word("R5 bank1 before delay", 1'b0, 4'b0011, 1'b0);
    hold(200);
    word("R5 bank1 after delay", 1'b1, 4'hF, 1'b1);
    release_all();
    seed_mode = 2'b11;
    press(4'b0011); hold(3400);
    word("R5 imm-only no delayed", 1'b0, 4'b0011, 1'b0);
    release_all();
  endtask

  task automatic t_restart();
    seed_bank = 1'b0; seed_mode = 2'b10;
    press(4'b0001); hold(1000);
    press(4'b0111); hold(10);
    press(4'b0001); hold(1000);
    word("R8 restart on change", 1'b0, 4'b0001, 1'b0);
    release_all();
    press(4'b0001); hold(1000);
    release_all();
    press(4'b0001); hold(1000);
    word("R8 cleared by release", 1'b0, 4'b0001, 1'b0);
    hold(700);
    word("R8 seed after full hold", 1'b1, 4'hF, 1'b1);
    release_all();
    chk("R8 release clears seed_sel", seed_sel, 0);
  endtask

  task automatic t_nomatch();
    seed_bank = 1'b0; seed_mode = 2'b10;
    press(4'b0111); hold(1700);
    word("R9 0111", 1'b0, 4'b0111, 1'b0);
    release_all();
    press(4'b1111); hold(2);
    word("R9 1111", 1'b0, 4'b1111, 1'b0);
    release_all();
    seed_bank = 1'b1;
    press(4'b0001); hold(3300);
    word("R9 bank0 delayed under bank1", 1'b0, 4'b0001, 1'b0);
    release_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; btn = 4'b0000; seed_bank = 1'b0; seed_mode = 2'b00;
    sync_cnt = 16'h0000; ms_tick = 1'b1; word_start = 1'b0;
    hold(3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    hold(2);
    t_imm_bank0();
    t_imm_bank1();
    t_disabled();
    t_limited();
    t_delay();
    t_restart();
    t_nomatch();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule